// File: doc/BRIEF.md
# Decimator Output-Rate and Settling Sequencer

This block sets the output cadence of an oversampled converter's decimation filter. It counts master clocks to mark the end of each conversion period and sends out one strobe per period. After a resynchronization it holds back the data-ready strobe until the filter has settled. The filter arithmetic is not part of the block. The filter result enters as an opaque word, and the block registers it whenever it issues data-ready, so nothing downstream has to throw samples away.

A synchronization request is a level. While it is high, the sequencer stays at zero and samples the ratio and speed selects. When it is released, a fixed startup overhead runs first and then period counting begins. A separate step-notify input marks a span of conversions as only partly settled. During that span the settled flag is low, but data keeps flowing.

Top module: `dec_rate_seq`

## Requirements
- R1: For a latched ratio select s (0..7), every conversion period lasts 2^(s+6) master clocks, which covers ratios 32 to 4096. conv_o pulses for one cycle at the end of each period.
- R2: While sync_i is high, conv_o, drdy_o, half_o and settled_o are low. restart_o is high for exactly one cycle after the first edge at which sync_i is high.
- R3: Counting the first edge with sync_i low as edge 0, the first conv_o is visible in the cycle after edge OVH_CYC+P-1, where P is the period length.
- R4: osr_sel_i and speed_sel_i are sampled only on edges where sync_i is high. speed_o shows the latched speed select. Changes made while sync_i is low have no effect on the period length or on speed_o.
- R5: drdy_o is high only together with conv_o. After a restart it stays low for the first 67 conversion ends and is high from the 68th onward.
- R6: half_o goes high with the 34th conversion end after a restart and stays high until the next sync.
- R7: settled_o goes high with the 68th conversion end. A step_i pulse on an edge that is not a period end forces settled_o low, and the next 69 conversions are output with settled_o low.
- R8: drdy_o keeps firing on every conversion end while the step window is open.
- R9: data_o takes the value of data_i on the edge that raises drdy_o, and holds that value at all other times.
- R10: During reset and after reset, until the first sync, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osr_sel_i | input | 3 | Oversampling ratio select, ratio = 32 << value |
| speed_sel_i | input | 1 | Speed mode select |
| sync_i | input | 1 | Synchronization level, active high |
| step_i | input | 1 | Input-step notification pulse |
| data_i | input | DATA_W | Filter output word |
| restart_o | output | 1 | Filter restart pulse |
| conv_o | output | 1 | Conversion period end strobe |
| drdy_o | output | 1 | Data-ready strobe |
| half_o | output | 1 | Group-delay point reached |
| settled_o | output | 1 | Output data fully settled |
| speed_o | output | 1 | Latched speed mode |
| data_o | output | DATA_W | Registered output word |

## Verification
If the period counter goes wrong, the spacing of conv_o changes at the very next period end. That is 64 clocks at the shortest ratio, and the error is off by whole clocks. If the conversion counter or the settling counter goes wrong, it does not show until much later. The first drdy_o, or the rising edge of half_o or settled_o, then arrives a whole period early or late, which can be as many as 68 periods after the sync. For this reason the bench follows every output on every cycle against a model of its own, and it also checks the exact edge index of the first strobe. A fault in the latch or the step window shows up as a wrong period length after an ignored select change, or as a number of unsettled data-ready strobes other than 69.

// File: rtl/dec_seq_pkg.sv
package dec_seq_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_OVH  = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/dec_period_timer.sv
module dec_period_timer
  import dec_seq_pkg::*;
#(
  parameter int unsigned OVH_CYC      = 8,
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned OSR_MIN_LOG2 = 5,
  parameter int unsigned PER_W        = OSR_MIN_LOG2 + (1 << SEL_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] osr_q_i,
  output logic             period_end_o
);
  localparam int unsigned OVH_W = $clog2(OVH_CYC + 1);

  phase_e           phase_q;
  logic [OVH_W-1:0] ovh_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last;

  // period = 2 * 2^(OSR_MIN_LOG2 + sel)
  assign last = (PER_W'(1) << (OSR_MIN_LOG2 + 1 + int'(osr_q_i))) - PER_W'(1);
  assign period_end_o = !sync_i && (phase_q == PH_RUN) && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      ovh_q   <= '0;
      cnt_q   <= '0;
    end else if (sync_i) begin
      phase_q <= PH_OVH;
      ovh_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_OVH: begin
          if (ovh_q == OVH_W'(OVH_CYC - 1)) phase_q <= PH_RUN;
          else ovh_q <= ovh_q + OVH_W'(1);
        end
        PH_RUN: cnt_q <= period_end_o ? '0 : cnt_q + PER_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dec_settle_track.sv
module dec_settle_track #(
  parameter int unsigned SETTLE_N = 68,
  parameter int unsigned HALF_N   = 34,
  parameter int unsigned PART_N   = 69
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic period_end_i,
  input  logic step_i,
  output logic emit_o,
  output logic half_o,
  output logic settled_o
);
  localparam int unsigned CNT_W  = $clog2(SETTLE_N + 1);
  localparam int unsigned PART_W = $clog2(PART_N + 1);

  logic [CNT_W-1:0]  n_q, n_next;
  logic [PART_W-1:0] part_q;
  logic              half_q, settled_q;
  logic              full_next;

  always_comb begin
    n_next = n_q;
    if (period_end_i && (n_q < CNT_W'(SETTLE_N))) n_next = n_q + CNT_W'(1);
  end

  assign full_next = (n_next == CNT_W'(SETTLE_N));
  assign emit_o    = period_end_i && full_next;
  assign half_o    = half_q;
  assign settled_o = settled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q       <= '0;
      part_q    <= '0;
      half_q    <= 1'b0;
      settled_q <= 1'b0;
    end else if (sync_i) begin
      n_q       <= '0;
      part_q    <= '0;
      half_q    <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      n_q    <= n_next;
      half_q <= (n_next >= CNT_W'(HALF_N));
      if (step_i) begin
        // step wins: window restarts from the following period
        part_q    <= PART_W'(PART_N);
        settled_q <= 1'b0;
      end else if (period_end_i) begin
        settled_q <= full_next && (part_q == '0);
        if (part_q != '0) part_q <= part_q - PART_W'(1);
      end
    end
  end
endmodule

// File: rtl/dec_rate_seq.sv
module dec_rate_seq #(
  parameter int unsigned DATA_W       = 24,
  parameter int unsigned OVH_CYC      = 8,
  parameter int unsigned OSR_MIN_LOG2 = 5,
  parameter int unsigned SETTLE_N     = 68,
  parameter int unsigned HALF_N       = 34,
  parameter int unsigned PART_N       = 69
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        osr_sel_i,
  input  logic              speed_sel_i,
  input  logic              sync_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              restart_o,
  output logic              conv_o,
  output logic              drdy_o,
  output logic              half_o,
  output logic              settled_o,
  output logic              speed_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned SEL_W = 3;

  logic [SEL_W-1:0]  osr_q;
  logic              speed_q, sync_prev_q, restart_q, conv_q, drdy_q;
  logic [DATA_W-1:0] data_q;
  logic              period_end, emit;

  // selects follow inputs only while sync holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osr_q   <= '0;
      speed_q <= 1'b0;
    end else if (sync_i) begin
      osr_q   <= osr_sel_i;
      speed_q <= speed_sel_i;
    end
  end

  dec_period_timer #(
    .OVH_CYC     (OVH_CYC),
    .SEL_W       (SEL_W),
    .OSR_MIN_LOG2(OSR_MIN_LOG2)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .osr_q_i     (osr_q),
    .period_end_o(period_end)
  );

  dec_settle_track #(
    .SETTLE_N(SETTLE_N),
    .HALF_N  (HALF_N),
    .PART_N  (PART_N)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .period_end_i(period_end),
    .step_i      (step_i),
    .emit_o      (emit),
    .half_o      (half_o),
    .settled_o   (settled_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b0;
      restart_q   <= 1'b0;
      conv_q      <= 1'b0;
      drdy_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      sync_prev_q <= sync_i;
      restart_q   <= sync_i && !sync_prev_q;
      conv_q      <= period_end;
      drdy_q      <= emit;
      if (emit) data_q <= data_i;
    end
  end

  assign restart_o = restart_q;
  assign conv_o    = conv_q;
  assign drdy_o    = drdy_q;
  assign speed_o   = speed_q;
  assign data_o    = data_q;
endmodule

// File: rtl/dec_rate_seq_chk.sv
module dec_rate_seq_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              restart_o,
  input logic              conv_o,
  input logic              drdy_o,
  input logic              half_o,
  input logic              settled_o,
  input logic              speed_o,
  input logic [DATA_W-1:0] data_o
);
  p_drdy_with_conv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |-> conv_o);

  p_sync_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (!conv_o && !drdy_o && !half_o && !settled_o));

  p_restart_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  p_half_before_drdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |-> half_o);

  p_settled_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> drdy_o);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_o |-> $stable(data_o));

  p_speed_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(speed_o));
endmodule

bind dec_rate_seq dec_rate_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sync_i   (sync_i),
  .restart_o(restart_o),
  .conv_o   (conv_o),
  .drdy_o   (drdy_o),
  .half_o   (half_o),
  .settled_o(settled_o),
  .speed_o  (speed_o),
  .data_o   (data_o)
);

// File: tb/dec_rate_seq_bench.sv
module dec_rate_seq_bench;
  localparam int OVH = 8;
  localparam int DW  = 24;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    osr = '0;
  logic          spd = 1'b0, sync = 1'b0, step = 1'b0;
  logic [DW-1:0] din = '0;
  logic          restart_o, conv_o, drdy_o, half_o, settled_o, speed_o;
  logic [DW-1:0] data_o;

  dec_rate_seq u_dec_rate_seq (
    .clk_i(clk), .rst_ni(rst_n), .osr_sel_i(osr), .speed_sel_i(spd),
    .sync_i(sync), .step_i(step), .data_i(din),
    .restart_o(restart_o), .conv_o(conv_o), .drdy_o(drdy_o), .half_o(half_o),
    .settled_o(settled_o), .speed_o(speed_o), .data_o(data_o)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int k, n, part;
  bit m_settled;
  logic [DW-1:0] m_data = '0;
  int first_conv, first_drdy, gap, cnt_conv, cnt_dr, cnt_dr_uns;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_sync(input int sel, input bit sp, input int hold);
    int bad = 0;
    @(posedge clk); #1;
    sync = 1'b1; osr = 3'(sel); spd = sp;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      if (i == 0) chk(restart_o == 1'b1, "R2", "restart pulse", restart_o, 1);
      if (i == 1) chk(restart_o == 1'b0, "R2", "restart single", restart_o, 0);
      if (conv_o || drdy_o || half_o || settled_o) bad++;
    end
    chk(bad == 0, "R2", "quiet while sync high", bad, 0);
    sync = 1'b0;
    k = 0; n = 0; part = 0; m_settled = 1'b0;
  endtask

  // cycle-accurate reference of the requirements
  task automatic run(input int ncyc, input int per, input int step_rel, input string tag);
    int e_conv = 0, e_drdy = 0, e_half = 0, e_set = 0, e_data = 0;
    int prev_conv = -1;
    bit endp, dr_e;
    first_conv = -1; first_drdy = -1; gap = -1;
    cnt_conv = 0; cnt_dr = 0; cnt_dr_uns = 0;
    for (int i = 0; i < ncyc; i++) begin
      din  = DW'(k * 7919 + 13);
      step = (i == step_rel);
      @(posedge clk);
      endp = (k >= OVH) && (((k - OVH + 1) % per) == 0);
      if (endp && n < 68) n++;
      dr_e = endp && (n >= 68);
      if (dr_e) m_data = din;
      if (step) begin
        part = 69; m_settled = 1'b0;
      end else if (endp) begin
        m_settled = (n >= 68) && (part == 0);
        if (part > 0) part--;
      end
      #1;
      if (conv_o !== endp) e_conv++;
      if (drdy_o !== dr_e) e_drdy++;
      if (half_o !== (n >= 34)) e_half++;
      if (settled_o !== m_settled) e_set++;
      if (data_o !== m_data) e_data++;
      if (conv_o) begin
        cnt_conv++;
        if (first_conv < 0) first_conv = k;
        else if (gap < 0) gap = k - prev_conv;
        prev_conv = k;
      end
      if (drdy_o) begin
        cnt_dr++;
        if (!settled_o) cnt_dr_uns++;
        if (first_drdy < 0) first_drdy = k;
      end
      k++;
    end
    step = 1'b0;
    chk(e_conv == 0, "R1", {tag, " conv cadence mismatches"}, e_conv, 0);
    chk(e_drdy == 0, "R5", {tag, " drdy mismatches"}, e_drdy, 0);
    chk(e_half == 0, "R6", {tag, " half mismatches"}, e_half, 0);
    chk(e_set == 0, "R7", {tag, " settled mismatches"}, e_set, 0);
    chk(e_data == 0, "R9", {tag, " data mismatches"}, e_data, 0);
  endtask

  task automatic t_reset();
    #1;
    chk({restart_o, conv_o, drdy_o, half_o, settled_o, speed_o} == 6'd0 && data_o == '0,
        "R10", "outputs in reset", {restart_o, conv_o, drdy_o, half_o, settled_o}, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(!conv_o && !drdy_o && !restart_o, "R10", "idle before first sync", conv_o, 0);
  endtask

  task automatic t_settle_osr32();
    do_sync(0, 0, 3);
    run(OVH + 68 * 64 + 40, 64, -1, "osr32");
    chk(first_conv == OVH + 64 - 1, "R3", "first conv edge", first_conv, OVH + 63);
    chk(first_drdy == OVH + 68 * 64 - 1, "R5", "first drdy edge", first_drdy, OVH + 68 * 64 - 1);
  endtask

  task automatic t_step_and_ignored_sel();
    osr = 3'd5; spd = 1'b1;  // no sync: must be ignored
    run(75 * 64, 64, 20, "step");
    chk(speed_o == 1'b0, "R4", "speed held without sync", speed_o, 0);
    chk(gap == 64, "R4", "period unchanged without sync", gap, 64);
    chk(cnt_dr_uns == 69, "R7", "unsettled drdy count", cnt_dr_uns, 69);
    chk(cnt_dr == cnt_conv, "R8", "drdy during step window", cnt_dr, cnt_conv);
  endtask

  task automatic t_osr4096();
    do_sync(7, 1, 2);
    run(OVH + 2 * 8192 + 4, 8192, -1, "osr4096");
    chk(first_conv == OVH + 8191, "R3", "first conv edge osr4096", first_conv, OVH + 8191);
    chk(gap == 8192, "R1", "period osr4096", gap, 8192);
    chk(speed_o == 1'b1, "R4", "speed latched on sync", speed_o, 1);
  endtask

  task automatic t_sync_hold();
    do_sync(0, 0, 100);
    run(OVH + 40 * 64, 64, -1, "after hold");
    chk(first_conv == OVH + 63, "R3", "restart after long hold", first_conv, OVH + 63);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    t_settle_osr32();
    t_step_and_ignored_sel();
    t_osr4096();
    t_sync_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule